// File: doc/BRIEF.md
# Serial Synthesizer Control Register

This block is the digital front end that a host uses to program a frequency synthesizer over a three-wire serial link. The three wires are an enable, a data line and a serial clock. The block oversamples the serial clock with its own system clock. While the enable is high, it takes one data bit on every falling serial-clock edge. It commits the received fields into holding registers at fixed bit counts. The holding registers drive the band-switch enables, the main and swallow divider values, and a set of test controls: charge-pump current, test mode, reference ratio select and tuning-amplifier disable.

A frame is 19 or 27 bits long, sent most significant field first. The first 4 bits are the band enables, first bit to `band_on[3]`. The next 10 bits are the main divider, MSB first. The next 5 bits are the swallow divider, MSB first. A 27-bit frame then adds 8 test bits. Band data is first held in a shadow register. It is committed at the 19th edge, or when the enable drops before that edge. This lets a short frame of 4 to 18 bits change only the bands.

A controller FSM runs the frame. Its states are IDLE, BAND, MAIN, TEST and FULL, and a saturating bit counter works alongside it. The transitions are:
- frame open: IDLE to BAND, on enable high.
- band captured: BAND to MAIN, on the 4th edge.
- counters committed: MAIN to TEST, on the 19th edge.
- test committed: TEST to FULL, on the 27th edge.
- abandon: any state to IDLE, on enable low.

Top module: `synth_ctl_top`

## Requirements
- R1: During and after synchronous reset, the outputs are: `band_on`=0, `m_div`=0, `s_div`=0, `cp_hi`=1, `tmode`=3'b010 (charge pump high impedance), `ref_a`=0, `ref_b`=0 (ratio 1/640), `tune_off`=1.
- R2: While `ser_en` is low, `ser_clk` and `ser_data` have no effect on any output.
- R3: Frame bits 1 to 4 map to `band_on[3]` down to `band_on[0]`, and 1 means on. Bits 5 to 14 are `m_div` MSB first. Bits 15 to 19 are `s_div` MSB first.
- R4: The 19th falling `ser_clk` edge commits `m_div`, `s_div` and `band_on` together. They are visible one system clock after the edge is sampled, and are unchanged after 18 edges.
- R5: If `ser_en` drops after 4 to 18 edges, only `band_on` updates, to the first 4 bits. The divider and test outputs keep their values.
- R6: If `ser_en` drops after fewer than 4 edges, no output changes.
- R7: The 27th edge commits the test bits. Bit 20 is ignored. Bit 21 goes to `cp_hi`, bits 22 to 24 to `tmode[2:0]`, bit 25 to `ref_a`, bit 26 to `ref_b` and bit 27 to `tune_off`.
- R8: A frame of 19 to 26 edges commits band and divider values but leaves the test outputs unchanged.
- R9: Edges after the 27th are ignored, and the bit count saturates at 27.
- R10: A low `ser_en` clears the bit count, so the next frame starts again at bit 1.
- R11: A `ser_clk` fall seen in the same system cycle that `ser_en` goes low is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial lines |
| rst | input | 1 | Synchronous power-on reset, active high |
| ser_en | input | 1 | Serial enable; a frame lasts while this is high |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| band_on | output | 4 | Band-switch enables |
| m_div | output | 10 | Main divider value |
| s_div | output | 5 | Swallow divider value |
| cp_hi | output | 1 | High charge-pump current select |
| tmode | output | 3 | Test mode bits |
| ref_a | output | 1 | Reference ratio select, first bit |
| ref_b | output | 1 | Reference ratio select, second bit |
| tune_off | output | 1 | Tuning amplifier disable |

## Verification
Two functions can fall in the same system cycle: the 19th counter commit and the band-only commit on enable loss. Both can be triggered by the same pair of wire changes. The bench sends 18 bits, then lowers `ser_clk` and `ser_en` on the same system clock. The result is judged correct only if the bands take the new shadow value while `m_div` and `s_div` keep their old values. A full frame sent afterwards must then commit normally, which shows that the count restarted at bit 1.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

    localparam int TEST_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BAND,
        ST_MAIN,
        ST_TEST,
        ST_FULL
    } ctl_state_e;

    typedef struct packed {
        logic       cp_hi;
        logic [2:0] tmode;
        logic       ref_a;
        logic       ref_b;
        logic       tune_off;
    } test_cfg_t;

    localparam test_cfg_t TEST_RESET = '{cp_hi: 1'b1, tmode: 3'b010,
                                         ref_a: 1'b0, ref_b: 1'b0,
                                         tune_off: 1'b1};

endpackage

// File: rtl/sctl_edge.sv
module sctl_edge (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_en,
    output logic fall
);
    logic clk_q;

    always_ff @(posedge clk) begin
        if (rst) clk_q <= 1'b0;
        else     clk_q <= ser_clk;
    end

    // A falling serial edge counts only while the frame is open.
    assign fall = clk_q & ~ser_clk & ser_en;
endmodule

// File: rtl/sctl_bitcnt.sv
module sctl_bitcnt #(
    parameter int LIMIT = 27,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr)               cnt <= '0;
        else if (step && cnt != TOP)  cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q_next
);
    logic [W-1:0] q;

    assign q_next = {q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (shift) q <= q_next;
    end
endmodule

// File: rtl/synth_ctl_top.sv
module synth_ctl_top
    import synth_ctl_pkg::*;
#(
    parameter int BAND_W = 4,
    parameter int M_W    = 10,
    parameter int S_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en,
    input  logic              ser_data,
    input  logic              ser_clk,
    output logic [BAND_W-1:0] band_on,
    output logic [M_W-1:0]    m_div,
    output logic [S_W-1:0]    s_div,
    output logic              cp_hi,
    output logic [2:0]        tmode,
    output logic              ref_a,
    output logic              ref_b,
    output logic              tune_off
);
    localparam int MAIN_END = BAND_W + M_W + S_W;
    localparam int FULL_END = MAIN_END + TEST_W;
    localparam int CNT_W    = $clog2(FULL_END + 1);
    localparam int SH_W     = (M_W + S_W > TEST_W) ? (M_W + S_W) : TEST_W;

    localparam logic [CNT_W-1:0] BAND_LAST = CNT_W'(BAND_W - 1);
    localparam logic [CNT_W-1:0] MAIN_LAST = CNT_W'(MAIN_END - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_END - 1);

    ctl_state_e        state, state_nx;
    logic              fall;
    logic [CNT_W-1:0]  cnt;
    logic [SH_W-1:0]   sh_next;
    logic [BAND_W-1:0] band_sh;
    test_cfg_t         test_q;

    sctl_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_en  (ser_en),
        .fall    (fall)
    );

    sctl_bitcnt #(.LIMIT(FULL_END), .CW(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (~ser_en),
        .step (fall),
        .cnt  (cnt)
    );

    sctl_shift #(.W(SH_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .shift  (fall),
        .din    (ser_data),
        .q_next (sh_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!ser_en) begin
            state_nx = ST_IDLE;                               // abandon
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_BAND;                  // frame open
                ST_BAND: if (fall && cnt == BAND_LAST) state_nx = ST_MAIN;
                ST_MAIN: if (fall && cnt == MAIN_LAST) state_nx = ST_TEST;
                ST_TEST: if (fall && cnt == FULL_LAST) state_nx = ST_FULL;
                ST_FULL: state_nx = ST_FULL;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Holding registers and band shadow
    always_ff @(posedge clk) begin
        if (rst) begin
            band_sh <= '0;
            band_on <= '0;
            m_div   <= '0;
            s_div   <= '0;
            test_q  <= TEST_RESET;
        end else begin
            unique case (state)
                ST_BAND: begin
                    if (fall && cnt == BAND_LAST)
                        band_sh <= sh_next[BAND_W-1:0];
                end
                ST_MAIN: begin
                    if (!ser_en) begin
                        band_on <= band_sh;
                    end else if (fall && cnt == MAIN_LAST) begin
                        band_on <= band_sh;
                        m_div   <= sh_next[M_W+S_W-1:S_W];
                        s_div   <= sh_next[S_W-1:0];
                    end
                end
                ST_TEST: begin
                    if (fall && cnt == FULL_LAST) begin
                        test_q.cp_hi    <= sh_next[6];
                        test_q.tmode    <= sh_next[5:3];
                        test_q.ref_a    <= sh_next[2];
                        test_q.ref_b    <= sh_next[1];
                        test_q.tune_off <= sh_next[0];
                    end
                end
                ST_IDLE, ST_FULL: ;
                default: ;
            endcase
        end
    end

    assign cp_hi    = test_q.cp_hi;
    assign tmode    = test_q.tmode;
    assign ref_a    = test_q.ref_a;
    assign ref_b    = test_q.ref_b;
    assign tune_off = test_q.tune_off;

endmodule

// File: rtl/synth_ctl_chk.sv
module synth_ctl_chk
    import synth_ctl_pkg::*;
#(
    parameter int BAND_W   = 4,
    parameter int M_W      = 10,
    parameter int S_W      = 5,
    parameter int CNT_W    = 5,
    parameter int FULL_END = 27
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_en,
    input ctl_state_e        state,
    input logic [CNT_W-1:0]  cnt,
    input logic [BAND_W-1:0] band_on,
    input logic [M_W-1:0]    m_div,
    input logic [S_W-1:0]    s_div,
    input logic              cp_hi,
    input logic [2:0]        tmode,
    input logic              ref_a,
    input logic              ref_b,
    input logic              tune_off
);
    logic [6:0] tst;
    assign tst = {cp_hi, tmode, ref_a, ref_b, tune_off};

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !ser_en |=> ($stable(m_div) && $stable(s_div) && $stable(tst)));

    p_partial_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAIN && !ser_en) |=> ($stable(m_div) && $stable(s_div)));

    p_short_r6: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_BAND || state == ST_IDLE) && !ser_en) |=> $stable(band_on));

    p_testonly_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_TEST) |=> $stable(tst));

    p_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FULL) |=> ($stable(band_on) && $stable(m_div)
                                && $stable(s_div) && $stable(tst)));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FULL_END));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !ser_en |=> (cnt == '0 && state == ST_IDLE));

endmodule

bind synth_ctl_top synth_ctl_chk #(
    .BAND_W(BAND_W), .M_W(M_W), .S_W(S_W), .CNT_W(CNT_W), .FULL_END(FULL_END)
) u_chk (
    .clk(clk), .rst(rst), .ser_en(ser_en), .state(state), .cnt(cnt),
    .band_on(band_on), .m_div(m_div), .s_div(s_div), .cp_hi(cp_hi),
    .tmode(tmode), .ref_a(ref_a), .ref_b(ref_b), .tune_off(tune_off)
);

// File: tb/tb_synth_ctl_top.sv
`timescale 1ns/1ps
module tb_synth_ctl_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_en = 1'b0, ser_data = 1'b0, ser_clk = 1'b0;
    logic [3:0] band_on;
    logic [9:0] m_div;
    logic [4:0] s_div;
    logic cp_hi, ref_a, ref_b, tune_off;
    logic [2:0] tmode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] e_band;
    logic [9:0] e_m;
    logic [4:0] e_s;
    logic [6:0] e_t;

    always #10 clk = ~clk;

    synth_ctl_top dut (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_data(ser_data),
        .ser_clk(ser_clk), .band_on(band_on), .m_div(m_div), .s_div(s_div),
        .cp_hi(cp_hi), .tmode(tmode), .ref_a(ref_a), .ref_b(ref_b),
        .tune_off(tune_off)
    );

    task automatic check_all(input string tag);
        logic [25:0] got, exp;
        got = {band_on, m_div, s_div, cp_hi, tmode, ref_a, ref_b, tune_off};
        exp = {e_band, e_m, e_s, e_t};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); ser_clk = 1'b1; ser_data = b;
        @(negedge clk); @(negedge clk); ser_clk = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic open_frame();
        @(negedge clk); ser_en = 1'b1; ser_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic close_frame();
        @(negedge clk); ser_en = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            report();
        end
    end

    initial begin
        logic [18:0] f19;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        e_band = 4'h0; e_m = 10'h0; e_s = 5'h0; e_t = 7'b1_010_0_0_1;
        check_all("R1 reset defaults");

        // R2: serial activity with enable low
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); ser_clk = 1'b1; ser_data = i[0];
            @(negedge clk); ser_clk = 1'b0;
            @(negedge clk);
        end
        check_all("R2 enable low ignored");

        // R3 R4: band sweep with 19-bit frames
        for (int k = 0; k < 16; k++) begin
            logic [9:0] m; logic [4:0] s;
            m = 10'((k * 67 + 5) % 1024);
            s = 5'((k * 11 + 3) % 32);
            f19 = {4'(k), m, s};
            open_frame();
            send(64'(f19 >> 1), 18);
            check_all("R4 no commit after 18 edges");
            bit_out(f19[0]);
            e_band = 4'(k); e_m = m; e_s = s;
            check_all("R4 commit at 19th edge");
            close_frame();
            check_all("R3 field order");
        end

        // R7: exhaustive test byte sweep with 27-bit frames
        for (int t = 0; t < 256; t++) begin
            logic [9:0] m; logic [4:0] s;
            m = 10'((t * 3 + 1) % 1024);
            s = 5'(t % 32);
            open_frame();
            send({37'b0, 4'(t), m, s, 8'(t)}, 27);
            close_frame();
            e_band = 4'(t); e_m = m; e_s = s; e_t = 7'(t);
            check_all("R7 test bits");
        end

        // R5 R6: short frames of 0..18 edges
        for (int n = 0; n <= 18; n++) begin
            f19 = {~e_band, ~e_m, ~e_s};
            open_frame();
            send(64'(f19 >> (19 - n)), n);
            close_frame();
            if (n >= 4) begin
                e_band = f19[18:15];
                check_all("R5 band-only update");
            end else begin
                check_all("R6 short frame ignored");
            end
        end

        // R8: frames of 19..26 edges
        for (int n = 19; n <= 26; n++) begin
            logic [26:0] f27;
            f27 = {~e_band, ~e_m, ~e_s, ~{1'b0, e_t}};
            open_frame();
            send(64'(f27 >> (27 - n)), n);
            close_frame();
            e_band = f27[26:23]; e_m = f27[22:13]; e_s = f27[12:8];
            check_all("R8 test held");
        end

        // R9: extra edges after the 27th
        begin
            logic [26:0] f27;
            f27 = {4'hA, 10'h2C5, 5'h13, 8'h5B};
            open_frame();
            send(64'(f27), 27);
            e_band = 4'hA; e_m = 10'h2C5; e_s = 5'h13; e_t = 7'h5B;
            send(64'hA5, 8);
            check_all("R9 extra edges ignored");
            close_frame();
            check_all("R9 after close");
        end

        // R11: enable drop together with a clock fall at count 18
        f19 = {4'h3, 10'h155, 5'h0A};
        open_frame();
        send(64'(f19 >> 1), 18);
        @(negedge clk); ser_clk = 1'b1; ser_data = f19[0];
        @(negedge clk); @(negedge clk);
        ser_clk = 1'b0; ser_en = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        e_band = 4'h3;
        check_all("R11 coincident edge not counted");

        // R10: next frame restarts at bit 1
        f19 = {4'hC, 10'h0F3, 5'h1E};
        open_frame();
        send(64'(f19), 19);
        close_frame();
        e_band = 4'hC; e_m = 10'h0F3; e_s = 5'h1E;
        check_all("R10 count restarts");

        done = 1'b1;
        report();
    end
endmodule